// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives asynchronous serial characters from a single line. The line passes through a synchronizer and is then sampled once per oversample tick. There are sixteen ticks per bit in normal mode and eight in double-speed mode. A falling edge starts a candidate frame. The start bit is confirmed by a vote of three samples in its centre, so a short spike does not start a frame. Each following data bit and the optional parity bit is decided by the same three-sample majority. The frame format is set per frame: five to nine data bits, LSB first, and parity that is none, even or odd.

Each completed character is stored in a two-entry queue together with a framing-error flag, a parity-error flag and an overrun flag. A completed character that finds the queue full waits in the shift stage. It is lost only if another start bit is confirmed before a read frees an entry. A consumer watches `rx_done`, reads the head entry from the output pins and pulses `rd_stb` to remove it. Clearing `rx_en` empties everything.

Top module: `ovs_rx`

## Requirements
- R1: After reset, `rx_done`, `rd_data`, `rd_ferr`, `rd_perr` and `rd_ovr` are all 0.
- R2: A frame candidate begins on a tick where the synchronized line is low and was high at the previous tick. That tick counts as sample 1. Later samples are numbered per tick, from 1 up to the bit length.
- R3: The start bit is accepted only when at least two of samples 8, 9 and 10 are low (samples 4, 5 and 6 in double speed). Otherwise the receiver stores nothing and waits for the next falling edge.
- R4: Every data bit and parity bit lasts 16 ticks (8 when `dbl_speed`=1). Its value is the majority of samples 8, 9 and 10 (4, 5 and 6) counted within that bit, so one wrong centre sample is outvoted.
- R5: `cfg_len` codes 0 to 4 select 5 to 9 data bits, and codes 5 to 7 act as 9. The first bit received lands in `rd_data[0]`, and the bits above the length read 0.
- R6: With `par_en`=1, one parity bit follows the data. `rd_perr` is 1 when that bit differs from the XOR of the data bits, inverted when `par_odd`=1. With `par_en`=0, `rd_perr` is 0.
- R7: `rd_ferr` is 1 when the first stop bit is voted low. The frame is stored at the clock edge that takes sample 10 (sample 6 in double speed) of the first stop bit. No later stop bit is examined.
- R8: The queue holds two characters and returns them in arrival order. `rx_done` is 1 exactly while unread data exists. A pulse on `rd_stb` while `rx_done`=1 removes the head.
- R9: A completed frame that finds both entries full waits in the shift stage. It enters the queue in the same clock that a read frees an entry, with no loss.
- R10: If a start bit is accepted while a frame still waits, the waiting frame is discarded. The next frame stored then carries `rd_ovr`=1. Every other stored frame carries `rd_ovr`=0.
- R11: While `rx_en`=0, the queue, the waiting frame and any pending overrun are cleared, and line activity is ignored. `rx_done` is 0 one clock after `rx_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes all state |
| line_in | input | 1 | Serial line, idle high, asynchronous |
| os_tick | input | 1 | One-clock pulse per oversample |
| dbl_speed | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| cfg_len | input | 3 | Data length code, 0..4 = 5..9 bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | Removes the head entry |
| rd_data | output | DATA_W | Head entry data, right-aligned |
| rd_ferr | output | 1 | Head entry framing error |
| rd_perr | output | 1 | Head entry parity error |
| rd_ovr | output | 1 | A frame was lost before the head entry |
| rx_done | output | 1 | Unread data present |

## Verification
The bench builds the receiver with `DATA_W`=9 and `SYNC_STAGES`=2. This makes the nine-bit length code and the clamp of the unused codes observable. The bench spaces oversample ticks four clocks apart, which is longer than the synchronizer delay. Each tick therefore samples exactly the level driven for it, so the sample numbering of start rejection, centre voting and store timing can be checked to the exact tick. Both speeds are exercised with single-sample noise placed on individual centre samples.

// File: rtl/ovs_rx.sv
module ovs_rx #(
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              line_in,
  input  logic              os_tick,
  input  logic              dbl_speed,
  input  logic [2:0]        cfg_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              rd_perr,
  output logic              rd_ovr,
  output logic              rx_done
);

  localparam int EW = DATA_W + 3;
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] NB_MAX = BW'(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [SYNC_STAGES-1:0] sy;
  logic                   ln_s, ln_q;
  st_t                    st;
  logic [4:0]             ph, cur, per, mid;
  logic [BW-1:0]          bi, nb;
  logic [3:0]             nb_raw;
  logic [1:0]             vt;
  logic [DATA_W-1:0]      sh;
  logic                   pb;
  logic                   take, vote, decide, bit_end;
  logic                   start_ok, frame_done;
  logic                   perr_new, ferr_new;

  logic [EW-1:0]          mem [2];
  logic                   wp, rp;
  logic [1:0]             cnt;
  logic                   wv, ovp;
  logic [EW-2:0]          wd;
  logic                   pop, room, wait_push, drop, push;
  logic [EW-2:0]          new_ent, push_ent;

  assign ln_s = sy[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '1;
    else        sy <= {sy[SYNC_STAGES-2:0], line_in};

  assign per  = dbl_speed ? 5'd8 : 5'd16;
  assign mid  = dbl_speed ? 5'd4 : 5'd8;
  assign cur  = (ph == per) ? 5'd1 : ph + 5'd1;
  assign take = os_tick && (st != S_IDLE);
  assign vote = (vt[1] & vt[0]) | (vt[1] & ln_s) | (vt[0] & ln_s);
  assign decide  = take && (cur == mid + 5'd2);
  assign bit_end = take && (cur == per);
  assign start_ok   = decide && (st == S_START) && !vote;
  assign frame_done = decide && (st == S_STOP);

  assign nb_raw = (cfg_len > 3'd4) ? 4'd9 : {1'b0, cfg_len} + 4'd5;
  assign nb     = (BW'(nb_raw) > NB_MAX) ? NB_MAX : BW'(nb_raw);

  assign perr_new = par_en & (pb ^ (^sh) ^ par_odd);
  assign ferr_new = !vote;
  assign new_ent  = {perr_new, ferr_new, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= '0;
      bi   <= '0;
      vt   <= '0;
      sh   <= '0;
      pb   <= 1'b0;
      ln_q <= 1'b1;
    end else if (!rx_en) begin
      st   <= S_IDLE;
      ln_q <= ln_s;
    end else if (os_tick) begin
      ln_q <= ln_s;
      if (st == S_IDLE) begin
        if (ln_q && !ln_s) begin
          st <= S_START;
          ph <= 5'd1;
          sh <= '0;
        end
      end else begin
        ph <= cur;
        if (cur == mid || cur == mid + 5'd1) vt <= {vt[0], ln_s};
        if (decide) begin
          case (st)
            S_START: if (vote) st <= S_IDLE;
            S_DATA:  sh[bi] <= vote;
            S_PAR:   pb <= vote;
            S_STOP:  st <= S_IDLE;
            default: ;
          endcase
        end
        if (bit_end) begin
          case (st)
            S_START: begin st <= S_DATA; bi <= '0; end
            S_DATA:
              if (bi == nb - BW'(1)) st <= par_en ? S_PAR : S_STOP;
              else                   bi <= bi + BW'(1);
            S_PAR:   st <= S_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  assign pop       = rd_stb && (cnt != 2'd0);
  assign room      = (cnt != 2'd2) || pop;
  assign wait_push = wv && room;
  assign drop      = start_ok && wv && !wait_push;
  assign push      = wait_push || (frame_done && room);
  assign push_ent  = wv ? wd : new_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      wp  <= 1'b0;
      rp  <= 1'b0;
      wv  <= 1'b0;
      wd  <= '0;
      ovp <= 1'b0;
      for (int i = 0; i < 2; i++) mem[i] <= '0;
    end else if (!rx_en) begin
      cnt <= '0;
      wp  <= 1'b0;
      rp  <= 1'b0;
      wv  <= 1'b0;
      ovp <= 1'b0;
    end else begin
      if (push) begin
        mem[wp] <= {ovp, push_ent};
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
      if (frame_done && !room) begin
        wv <= 1'b1;
        wd <= new_ent;
      end else if (wait_push || drop) begin
        wv <= 1'b0;
      end
      if (drop)      ovp <= 1'b1;
      else if (push) ovp <= 1'b0;
    end
  end

  assign rd_data = mem[rp][DATA_W-1:0];
  assign rd_ferr = mem[rp][DATA_W];
  assign rd_perr = mem[rp][DATA_W+1];
  assign rd_ovr  = mem[rp][DATA_W+2];
  assign rx_done = (cnt != 2'd0);

endmodule

// File: rtl/ovs_rx_chk.sv
module ovs_rx_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              os_tick,
  input logic              rd_stb,
  input logic              rx_done,
  input logic [DATA_W-1:0] rd_data
);

  AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done); // R11

  AST_STORE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(os_tick)); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_stb && rx_en) |=> rx_done); // R8

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_stb && rx_en) |=> $stable(rd_data)); // R9

endmodule

bind ovs_rx ovs_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rx_en   (rx_en),
  .os_tick (os_tick),
  .rd_stb  (rd_stb),
  .rx_done (rx_done),
  .rd_data (rd_data)
);

// File: tb/test_ovs_rx.sv
module test_ovs_rx;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic       line_in = 1'b1;
  logic       os_tick = 1'b0;
  logic       dbl_speed = 1'b0;
  logic [2:0] cfg_len = 3'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_stb = 1'b0;
  logic [8:0] rd_data;
  logic       rd_ferr, rd_perr, rd_ovr, rx_done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ovs_rx i_ovs_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .line_in(line_in),
    .os_tick(os_tick), .dbl_speed(dbl_speed), .cfg_len(cfg_len),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .rd_ovr(rd_ovr), .rx_done(rx_done)
  );

  // {dbl, len[2:0], pen, podd, flip_par, bad_stop, exp_perr, exp_ferr, data[8:0]}
  localparam logic [18:0] VEC [10] = '{
    {1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
    {1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h013},
    {1'b1, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1A5},
    {1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h05A},
    {1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h02C},
    {1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0F3},
    {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000},
    {1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0FF},
    {1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C3},
    {1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [2:0] c);
    return (c > 3'd4) ? 9 : int'(c) + 5;
  endfunction

  task automatic smp(input logic v);
    line_in = v;
    repeat (3) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) smp(1'b1);
  endtask

  task automatic send_frame(input logic dbl, input logic [2:0] len, input logic pen,
                            input logic podd, input logic flip, input logic bstop,
                            input logic [8:0] data, input int noise, input int snoise,
                            input int stop_n);
    int sp = dbl ? 8 : 16;
    int nb = nbits(len);
    logic [8:0] m = 9'((1 << nb) - 1);
    logic p = (^(data & m)) ^ podd ^ flip;
    dbl_speed = dbl; cfg_len = len; par_en = pen; par_odd = podd;
    idle(2);
    for (int s = 1; s <= sp; s++) smp(s == snoise);
    for (int i = 0; i < nb; i++)
      for (int s = 1; s <= sp; s++) smp(data[i] ^ (s == noise));
    if (pen) for (int s = 1; s <= sp; s++) smp(p);
    for (int s = 1; s <= stop_n; s++) smp(!bstop);
  endtask

  task automatic pop();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rx_done", rx_done, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 flags", {rd_ferr, rd_perr, rd_ovr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5 R6 R7 R8: table walk
    for (int v = 0; v < 10; v++) begin
      logic [18:0] e = VEC[v];
      int nb = nbits(e[17:15]);
      logic [8:0] m = 9'((1 << nb) - 1);
      send_frame(e[18], e[17:15], e[14], e[13], e[12], e[11], e[8:0], 0, 0, e[18] ? 8 : 16);
      idle(2);
      check("R8 done after frame", rx_done, 1);
      check("R5 data", rd_data, e[8:0] & m);
      check("R6 parity error", rd_perr, e[10]);
      check("R7 framing error", rd_ferr, e[9]);
      check("R10 no overrun", rd_ovr, 0);
      pop();
      check("R8 empty after read", rx_done, 0);
    end

    // R3: false start, normal speed, samples 8..10 high
    dbl_speed = 1'b0; cfg_len = 3'd3; par_en = 1'b0;
    idle(2);
    for (int s = 1; s <= 7; s++) smp(1'b0);
    idle(60);
    check("R3 spike rejected", rx_done, 0);
    // R3: sample 8 low but 9,10 high -> rejected
    for (int s = 1; s <= 8; s++) smp(1'b0);
    idle(60);
    check("R3 minority low rejected", rx_done, 0);
    // R3: double speed, samples 4..6 high
    dbl_speed = 1'b1;
    idle(2);
    for (int s = 1; s <= 3; s++) smp(1'b0);
    idle(40);
    check("R3 dbl spike rejected", rx_done, 0);

    // R3 R4: one noisy sample in start and in every data bit is outvoted
    send_frame(1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0A6, 9, 9, 16);
    idle(2);
    check("R4 noisy normal data", rd_data, 9'h0A6);
    check("R4 noisy normal parity", rd_perr, 0);
    pop();
    send_frame(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 9'h13C, 4, 5, 8);
    idle(2);
    check("R4 noisy dbl data", rd_data, 9'h13C);
    pop();

    // R7: store happens on stop sample 10
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h03C, 0, 0, 9);
    check("R7 not stored at stop sample 9", rx_done, 0);
    smp(1'b1);
    check("R7 stored at stop sample 10", rx_done, 1);
    idle(8);
    check("R7 data", rd_data, 9'h03C);
    pop();

    // R8 R9: three frames, third waits then enters on read
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A1, 0, 0, 16);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0B2, 0, 0, 16);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0C3, 0, 0, 16);
    idle(2);
    check("R8 first in order", rd_data, 9'h0A1);
    pop();
    check("R8 second in order", rd_data, 9'h0B2);
    pop();
    check("R9 waiting frame kept", rd_data, 9'h0C3);
    check("R9 no overrun", rd_ovr, 0);
    pop();
    check("R8 drained", rx_done, 0);

    // R10: fourth frame start drops waiting third
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h011, 0, 0, 16);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h022, 0, 0, 16);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h033, 0, 0, 16);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h044, 0, 0, 16);
    idle(2);
    check("R10 head ovr clear", rd_ovr, 0);
    pop();
    check("R10 second ovr clear", {rd_ovr, rd_data}, {1'b0, 9'h022});
    pop();
    check("R10 survivor data", rd_data, 9'h044);
    check("R10 survivor ovr", rd_ovr, 1);
    pop();
    check("R10 drained", rx_done, 0);

    // R11: disable flushes and ignores line
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h05E, 0, 0, 16);
    idle(2);
    check("R11 frame present", rx_done, 1);
    rx_en = 1'b0;
    @(negedge clk);
    check("R11 flushed", rx_done, 0);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0E7, 0, 0, 16);
    idle(2);
    rx_en = 1'b1;
    idle(4);
    check("R11 line ignored", rx_done, 0);
    send_frame(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h07D, 0, 0, 16);
    idle(2);
    check("R11 resumes", {rx_done, rd_ovr, rd_data}, {1'b1, 1'b0, 9'h07D});
    pop();

    finish_run();
  end
endmodule